// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block connects two 32-bit registers in a host configuration window to an internal sideband message bus. Software first places a payload in the data register when a write is needed. It then writes a command word to the control register. That write is the only trigger. The bridge decodes the opcode, target port, register offset and byte enables from the command word and issues exactly one request toward the addressed target unit. A write request carries whatever the data register held when the command was written. A read request deposits the target's response into the data register.

Only one transaction is in flight at a time. While a request is outstanding, the block raises a busy flag. A command written during that time is discarded, and a sticky error flag records the loss. A command with an unknown opcode, or one that names a port with no attached target, finishes at once without touching the bus. A set parameter bitmask says which ports have a target attached; by default only port 0x3, the memory-arbiter unit, is present.

Top module: `sb_bridge`

## Requirements
- R1: Offset 0xD0 reads back the last accepted command word and offset 0xD4 reads back the data register. Any other offset reads as zero.
- R2: Command bits 3:0 are discarded when written and always read back as zero.
- R3: A command with opcode 0xE0 (bits 31:24) to a present port issues one write request. The request carries the port from bits 23:16, the offset from bits 15:8 and the byte enables from bits 7:4. Its payload is the data-register value at the moment the command was written.
- R4: A command with opcode 0xD0 to a present port issues one read request, with the request byte enables forced to 0xF. The response data is stored in the data register when the response arrives.
- R5: A request stays asserted, with stable fields, until the response strobe arrives, and it drops in the following cycle. The busy flag is high from the cycle after the command until the cycle after the response.
- R6: A command with any opcode other than 0xD0 or 0xE0, or a read to a port with no target, issues no request, does not raise busy, and loads 0xFFFFFFFF into the data register. A write to a port with no target issues no request and leaves the data register unchanged.
- R7: A command written while busy is dropped. The stored command word is unchanged, no extra request is issued, and the error flag sets and stays set until reset.
- R8: After reset both registers read zero, and busy, error and request are low.
- R9: Writing the data register while a write transaction is in flight does not alter that transaction's payload. The new value remains in the data register after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Host register write strobe |
| cfg_addr_i | input | 8 | Host register byte offset |
| cfg_wdata_i | input | 32 | Host write data |
| cfg_rdata_o | output | 32 | Host read data for cfg_addr_i (combinational) |
| busy_o | output | 1 | Transaction in flight |
| err_o | output | 1 | Sticky flag: a command was dropped while busy |
| req_valid_o | output | 1 | Sideband request asserted |
| req_write_o | output | 1 | 1 = write request, 0 = read request |
| req_port_o | output | 8 | Destination port |
| req_offset_o | output | 8 | Target register offset |
| req_be_o | output | 4 | Byte enables (0xF on reads) |
| req_wdata_o | output | 32 | Write payload |
| rsp_valid_i | input | 1 | Target response strobe, ends the request |
| rsp_rdata_i | input | 32 | Target read data |

## Verification
The hardest situation to reach is a second command, or a new data-register value, arriving while a request is still outstanding. The bench makes its responder model hold the response for several cycles. In that window it writes the data register and then a fresh command. It then checks that the in-flight payload is the old value, that the command readback is unchanged, and that the error flag is set. Byte-lane merging is swept over all sixteen enable patterns, on several offsets, with response latencies from zero to two cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int DW     = 32;
  localparam int PORT_W = 8;
  localparam int OFS_W  = 8;
  localparam int BE_W   = DW / 8;

  localparam logic [7:0] OP_READ  = 8'hD0;
  localparam logic [7:0] OP_WRITE = 8'hE0;

  typedef struct packed {
    logic [7:0]        op;
    logic [PORT_W-1:0] port;
    logic [OFS_W-1:0]  ofs;
    logic [BE_W-1:0]   be;
    logic [3:0]        rsvd;
  } cmd_t;
endpackage

// File: rtl/sb_host_regs.sv
module sb_host_regs
  import sb_pkg::*;
#(
  parameter int          CFG_AW   = 8,
  parameter logic [7:0]  CTL_ADDR = 8'hD0,
  parameter logic [7:0]  DAT_ADDR = 8'hD4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic              busy_i,
  input  logic              upd_i,
  input  logic [DW-1:0]     upd_data_i,
  output logic              start_o,
  output cmd_t              cmd_o,
  output logic [DW-1:0]     data_o,
  output logic              err_o
);
  logic          ctl_hit, dat_hit;
  cmd_t          ctl_q;
  logic [DW-1:0] data_q;
  logic          err_q;

  assign ctl_hit = cfg_wr_i && (cfg_addr_i == CFG_AW'(CTL_ADDR));
  assign dat_hit = cfg_wr_i && (cfg_addr_i == CFG_AW'(DAT_ADDR));
  assign start_o = ctl_hit && !busy_i;

  always_comb begin
    cmd_o      = cmd_t'(cfg_wdata_i);
    cmd_o.rsvd = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (start_o) ctl_q <= cmd_o;
      if (ctl_hit && busy_i) err_q <= 1'b1;
      // completion result wins over a same-cycle host write
      if (upd_i)        data_q <= upd_data_i;
      else if (dat_hit) data_q <= cfg_wdata_i;
    end
  end

  always_comb begin
    if (cfg_addr_i == CFG_AW'(CTL_ADDR))      cfg_rdata_o = ctl_q;
    else if (cfg_addr_i == CFG_AW'(DAT_ADDR)) cfg_rdata_o = data_q;
    else                                      cfg_rdata_o = '0;
  end

  assign data_o = data_q;
  assign err_o  = err_q;

  AST_DROP_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_hit && busy_i) |=> err_o) else $error("drop without error"); // R7
  AST_DROP_KEEPS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_hit && busy_i) |=> $stable(ctl_q)) else $error("dropped cmd stored"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o) else $error("error flag cleared"); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == CFG_AW'(CTL_ADDR)) |-> (cfg_rdata_o[3:0] == 4'h0)) else $error("rsvd bits"); // R2
endmodule

// File: rtl/sb_seq.sv
module sb_seq
  import sb_pkg::*;
#(
  parameter logic [(1<<PORT_W)-1:0] PORT_PRESENT = 'h8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic [DW-1:0]     data_i,
  input  logic              rsp_valid_i,
  input  logic [DW-1:0]     rsp_rdata_i,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [PORT_W-1:0] req_port_o,
  output logic [OFS_W-1:0]  req_ofs_o,
  output logic [BE_W-1:0]   req_be_o,
  output logic [DW-1:0]     req_wdata_o,
  output logic              upd_o,
  output logic [DW-1:0]     upd_data_o
);
  typedef enum logic {ST_IDLE, ST_REQ} st_e;
  st_e state_q;

  logic is_rd, is_wr, present, go, skip_wr;

  assign is_rd   = (cmd_i.op == OP_READ);
  assign is_wr   = (cmd_i.op == OP_WRITE);
  assign present = PORT_PRESENT[cmd_i.port];
  assign go      = start_i && (is_rd || is_wr) && present;
  assign skip_wr = is_wr && !present;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_write_o <= 1'b0;
      req_port_o  <= '0;
      req_ofs_o   <= '0;
      req_be_o    <= '0;
      req_wdata_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin
          state_q     <= ST_REQ;
          req_write_o <= is_wr;
          req_port_o  <= cmd_i.port;
          req_ofs_o   <= cmd_i.ofs;
          req_be_o    <= is_wr ? cmd_i.be : {BE_W{1'b1}};
          req_wdata_o <= data_i;
        end
        ST_REQ: if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_REQ);
  assign req_valid_o = busy_o;

  always_comb begin
    upd_o      = 1'b0;
    upd_data_o = '1;
    if (busy_o && rsp_valid_i && !req_write_o) begin
      upd_o      = 1'b1;
      upd_data_o = rsp_rdata_i;
    end else if (start_i && !go && !skip_wr) begin
      upd_o = 1'b1;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o) else $error("start while busy"); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !rsp_valid_i) |=> (req_valid_o && $stable(req_port_o) && $stable(req_ofs_o)
      && $stable(req_be_o) && $stable(req_wdata_o) && $stable(req_write_o))) else $error("req unstable"); // R5
  AST_REQ_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && rsp_valid_i) |=> !req_valid_o) else $error("req not ended"); // R5
  AST_RD_BE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_write_o) |-> (req_be_o == {BE_W{1'b1}})) else $error("read be"); // R4
  AST_PORT_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> PORT_PRESENT[req_port_o]) else $error("absent port"); // R6
endmodule

// File: rtl/sb_bridge.sv
module sb_bridge
  import sb_pkg::*;
#(
  parameter int                      CFG_AW       = 8,
  parameter logic [7:0]              CTL_ADDR     = 8'hD0,
  parameter logic [7:0]              DAT_ADDR     = 8'hD4,
  parameter logic [(1<<PORT_W)-1:0]  PORT_PRESENT = 'h8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [7:0]        req_port_o,
  output logic [7:0]        req_offset_o,
  output logic [3:0]        req_be_o,
  output logic [31:0]       req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_rdata_i
);
  logic          start, upd;
  cmd_t          cmd;
  logic [DW-1:0] data, upd_data;

  sb_host_regs #(
    .CFG_AW(CFG_AW), .CTL_ADDR(CTL_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .busy_i(busy_o), .upd_i(upd), .upd_data_i(upd_data),
    .start_o(start), .cmd_o(cmd), .data_o(data), .err_o
  );

  sb_seq #(.PORT_PRESENT(PORT_PRESENT)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .data_i(data),
    .rsp_valid_i, .rsp_rdata_i, .busy_o, .req_valid_o, .req_write_o,
    .req_port_o, .req_ofs_o(req_offset_o), .req_be_o, .req_wdata_o,
    .upd_o(upd), .upd_data_o(upd_data)
  );
endmodule

// File: tb/sb_bridge_tb.sv
module sb_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        busy, err, req_valid, req_write;
  logic [7:0]  req_port, req_ofs;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  sb_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .busy_o(busy), .err_o(err),
    .req_valid_o(req_valid), .req_write_o(req_write), .req_port_o(req_port),
    .req_offset_o(req_ofs), .req_be_o(req_be), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata)
  );

  int checks = 0, fails = 0;
  int lat = 0, req_count = 0;
  logic        last_write;
  logic [7:0]  last_port, last_ofs;
  logic [3:0]  last_be;
  logic [31:0] last_wdata;
  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // target model on port 3: byte-lane masked writes, configurable latency
  initial begin
    int wcnt = 0;
    logic [31:0] m;
    logic [7:0]  h_port, h_ofs;
    logic [3:0]  h_be;
    logic [31:0] h_wd;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (!req_valid) wcnt = 0;
      else begin
        if (wcnt == 0) begin
          h_port = req_port; h_ofs = req_ofs; h_be = req_be; h_wd = req_wdata;
        end else begin
          chk(req_port == h_port && req_ofs == h_ofs && req_be == h_be && req_wdata == h_wd,
              "R5 request stable", req_wdata, h_wd);
        end
        if (wcnt >= lat) begin
          rsp_valid  = 1'b1;
          rsp_rdata  = mem[req_ofs];
          last_write = req_write; last_port = req_port; last_ofs = req_ofs;
          last_be    = req_be;    last_wdata = req_wdata;
          if (req_write) begin
            m = mem[req_ofs];
            for (int b = 0; b < 4; b++)
              if (req_be[b]) m[b*8 +: 8] = req_wdata[b*8 +: 8];
            mem[req_ofs] = m;
          end
          req_count++;
          wcnt = -1;
        end
        wcnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    finish_test();
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, wd, cmd, msk, exp;
    int c0;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = ~(32'h01010101 * i);
      shadow[i] = ~(32'h01010101 * i);
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && err == 0 && req_valid == 0, "R8 flags after reset", {busy, err, req_valid}, 0);
    cfg_read(8'hD0, rd); chk(rd == 0, "R8 ctl reset", rd, 0);
    rst_n = 1'b1;
    cfg_read(8'hD4, rd); chk(rd == 0, "R8 data reset", rd, 0);
    cfg_read(8'h40, rd); chk(rd == 0, "R1 unmapped offset", rd, 0);

    // R3/R4/R2/R1 sweep over offsets and all byte-enable patterns
    for (int ofs = 0; ofs < 6; ofs++) begin
      for (int be = 0; be < 16; be++) begin
        lat = (ofs + be) % 3;
        wd  = 32'h9E3779B9 * (ofs * 16 + be + 1);
        cfg_write(8'hD4, wd);
        cfg_read(8'hD4, rd); chk(rd == wd, "R1 data readback", rd, wd);
        c0  = req_count;
        cmd = {8'hE0, 8'h03, 8'(ofs), 4'(be), 4'(be ^ 5)};
        cfg_write(8'hD0, cmd);
        chk(busy == 1, "R5 busy after write cmd", busy, 1);
        cfg_read(8'hD0, rd); chk(rd == {cmd[31:4], 4'h0}, "R2 R1 ctl readback", rd, {cmd[31:4], 4'h0});
        wait_idle();
        chk(busy == 0 && req_valid == 0, "R5 idle after response", {busy, req_valid}, 0);
        chk(req_count == c0 + 1, "R3 one request", req_count, c0 + 1);
        chk(last_write && last_port == 8'h03 && last_ofs == 8'(ofs) && last_be == 4'(be),
            "R3 request fields", {last_write, last_port, last_ofs, last_be}, {1'b1, 8'h03, 8'(ofs), 4'(be)});
        chk(last_wdata == wd, "R3 payload", last_wdata, wd);
        msk = 0;
        for (int b = 0; b < 4; b++) if (be[b]) msk = msk | (32'hFF << (8 * b));
        shadow[ofs] = (shadow[ofs] & ~msk) | (wd & msk);
        cfg_read(8'hD4, rd); chk(rd == wd, "R3 data kept after write", rd, wd);
        c0 = req_count;
        cfg_write(8'hD0, {8'hD0, 8'h03, 8'(ofs), 4'(be), 4'h0});
        wait_idle();
        chk(req_count == c0 + 1 && !last_write, "R4 one read request", req_count, c0 + 1);
        chk(last_be == 4'hF, "R4 read be forced", last_be, 4'hF);
        exp = shadow[ofs];
        cfg_read(8'hD4, rd); chk(rd == exp, "R4 read data", rd, exp);
      end
    end

    // R6 invalid opcodes, absent ports
    lat = 0;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'h00 : (k == 1) ? 8'hD1 : (k == 2) ? 8'hE1 : (k == 3) ? 8'hFF : (k == 4) ? 8'hC0 : 8'h0D;
      cfg_write(8'hD4, 32'h12345678);
      c0 = req_count;
      cfg_write(8'hD0, {op, 8'h03, 8'h01, 4'hF, 4'h0});
      chk(busy == 0 && req_valid == 0, "R6 bad opcode no busy", {busy, req_valid}, 0);
      @(negedge clk);
      chk(req_count == c0, "R6 bad opcode no request", req_count, c0);
      cfg_read(8'hD4, rd); chk(rd == 32'hFFFFFFFF, "R6 bad opcode all ones", rd, 32'hFFFFFFFF);
    end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pt;
      pt = (k == 0) ? 8'h00 : (k == 1) ? 8'h02 : (k == 2) ? 8'h04 : 8'hFF;
      cfg_write(8'hD4, 32'hCAFE0000 + k);
      c0 = req_count;
      cfg_write(8'hD0, {8'hE0, pt, 8'h02, 4'hF, 4'h0});
      chk(busy == 0, "R6 absent write no busy", busy, 0);
      @(negedge clk);
      chk(req_count == c0, "R6 absent write no request", req_count, c0);
      cfg_read(8'hD4, rd); chk(rd == 32'hCAFE0000 + k, "R6 absent write data kept", rd, 32'hCAFE0000 + k);
      cfg_write(8'hD0, {8'hD0, pt, 8'h02, 4'hF, 4'h0});
      @(negedge clk);
      chk(req_count == c0, "R6 absent read no request", req_count, c0);
      cfg_read(8'hD4, rd); chk(rd == 32'hFFFFFFFF, "R6 absent read all ones", rd, 32'hFFFFFFFF);
    end
    chk(err == 0, "R7 no error yet", err, 0);

    // R7 / R9 overlap with a slow target
    lat = 6;
    cfg_write(8'hD4, 32'hAAAA0000);
    c0 = req_count;
    cmd = {8'hE0, 8'h03, 8'h05, 4'hF, 4'h0};
    cfg_write(8'hD0, cmd);
    cfg_write(8'hD4, 32'h5555FFFF);
    cfg_write(8'hD0, {8'hD0, 8'h03, 8'h06, 4'hF, 4'h0});
    chk(err == 1, "R7 error set on drop", err, 1);
    cfg_read(8'hD0, rd); chk(rd == cmd, "R7 ctl unchanged", rd, cmd);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(req_count == c0 + 1, "R7 no extra request", req_count, c0 + 1);
    chk(last_wdata == 32'hAAAA0000, "R9 payload latched", last_wdata, 32'hAAAA0000);
    cfg_read(8'hD4, rd); chk(rd == 32'h5555FFFF, "R9 new data kept", rd, 32'h5555FFFF);
    lat = 0;
    cfg_write(8'hD0, {8'hD0, 8'h03, 8'h05, 4'hF, 4'h0});
    wait_idle();
    chk(err == 1, "R7 error sticky", err, 1);
    cfg_read(8'hD4, rd); chk(rd == 32'hAAAA0000, "R4 read after overlap", rd, 32'hAAAA0000);

    // R8 reset clears error
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(err == 0 && busy == 0, "R8 reset clears flags", {err, busy}, 0);
    cfg_read(8'hD4, rd); chk(rd == 0, "R8 data cleared", rd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_test();
  end
endmodule